// File: doc/BRIEF.md
# Multi-Channel Quadrature Position Counter with Flag Interrupts

The block tracks the position of several incremental encoders at once. Each channel samples its A/B pair and index line through a two-flop synchronizer and steps a wide up/down counter. The counter advances once per cycle, once per half cycle or once per edge, depending on the resolution the host selects. Every channel also has a preset register, which serves both as the load value for the counter and as the match value for comparisons. A per-channel flag pin reports one event function that the host picks: wrap past the top of the range, a match against the preset, a wrap in either direction, or the raw index level.

A host reaches the block over a byte-wide register bus with a registered read path. Active channel flags are captured into a shared status register while the interrupt function is enabled. The OR of the status bits drives a single interrupt request line. A channel-operation register resets every counter at once and gates the interrupt function. A separate clear register wipes all pending status and event state.

Top module: `qenc_irq_counter`

## Requirements
- R1: The counter is CW bits wide (default 25). The preset register holds only the lower CW-1 bits: writes to preset byte lanes above them are dropped, and a load (control register bit 0, channel offset 5) copies the preset into the counter with the top bit cleared. Control bit 1 clears the counter.
- R2: Bits [4:3] of the channel mode byte (channel offset 4) pick the resolution. 01 (0x08) counts one step per full encoder cycle, on the A rising edge with B high. 10 (0x10) counts on both A edges. 11 (0x18) counts every valid transition. 00 holds the count.
- R3: Phase order {A,B} = 00, 01, 11, 10 counts up and the reverse order counts down. A sample in which both A and B change leaves the count unchanged.
- R4: Function code 0 (mode bits [1:0]) selects the carry flag. This is an active-low toggle that flips each time the counter wraps from all ones to zero.
- R5: Function code 2 selects carry-or-borrow. The borrow toggle flips on each wrap from zero to all ones, and the pin is low while either toggle is active. Under code 0 the borrow toggle has no effect on the pin.
- R6: Function code 1 selects the compare flag. This is an active-low toggle that flips each time a count step lands on the preset value. Loads and clears do not flip it.
- R7: Function code 3 makes the flag pin follow the synchronized index input, active high.
- R8: While the interrupt function is enabled, a channel's status bit (register 0x10, bit = channel number) is set whenever its flag is active, and `irq` is the registered OR of the status bits. Writing a 1 to a bit clears it, but it is captured again on the next cycle if the flag is still active. While the function is disabled, no status bit is set and `irq` is low.
- R9: Writing 0x01 to register 0x11 zeroes all counters, resets all toggles and disables the interrupt function. Writing 0x04 enables it. Any other value is ignored. Reading 0x11 returns the enable in bit 0.
- R10: Writing 0x00 to register 0x12 clears every status bit and returns every carry, borrow and compare toggle to inactive.
- R11: Channel n is mapped at 0x80 + 16n. Offsets 0 to 3 read the count one byte at a time, least significant byte first, and offsets 0 to 2 write the preset bytes. Read data appears on `bus_rdata` one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address for both reads and writes |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the previous cycle's address |
| enc_a | input | NCH | Encoder A phase, one bit per channel |
| enc_b | input | NCH | Encoder B phase, one bit per channel |
| enc_idx | input | NCH | Encoder index, one bit per channel |
| flag_pin | output | NCH | Per-channel flag pin, registered |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions take for granted that the bus carries at most one write per cycle and that a count may change only through a decoded step or a bus write. With no strobe and no step, the counters must hold. Encoder inputs are assumed to change slowly compared with the clock. The stimulus holds each encoder phase for four clocks, so every synchronized transition is seen once. Illegal two-bit jumps are driven on purpose, and they are taken as a known case rather than a glitch. Index levels are held for several clocks, and bus writes are issued one at a time on falling edges.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  typedef enum logic [1:0] {
    FN_CARRY        = 2'd0,
    FN_COMPARE      = 2'd1,
    FN_CARRY_BORROW = 2'd2,
    FN_INDEX        = 2'd3
  } flag_fn_e;

  typedef enum logic [1:0] {
    RES_HOLD = 2'd0,
    RES_X1   = 2'd1,
    RES_X2   = 2'd2,
    RES_X4   = 2'd3
  } res_e;

  localparam logic [7:0] ADDR_STATUS = 8'h10;
  localparam logic [7:0] ADDR_CHOP   = 8'h11;
  localparam logic [7:0] ADDR_CLEAR  = 8'h12;
  localparam logic [7:0] CHOP_RESET  = 8'h01;
  localparam logic [7:0] CHOP_ENABLE = 8'h04;
  localparam logic [3:0] OFS_MODE    = 4'd4;
  localparam logic [3:0] OFS_CTRL    = 4'd5;
endpackage

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic a,
  input  logic b,
  input  logic idx,
  input  res_e res,
  output logic up,
  output logic dn,
  output logic idx_s
);
  logic [SYNC-1:0] sa, sb, si;
  logic [1:0] prev, cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      sa <= '0;
      sb <= '0;
      si <= '0;
      prev <= 2'b00;
    end else begin
      sa <= {sa[SYNC-2:0], a};
      sb <= {sb[SYNC-2:0], b};
      si <= {si[SYNC-2:0], idx};
      prev <= cur;
    end
  end

  assign cur   = {sa[SYNC-1], sb[SYNC-1]};
  assign idx_s = si[SYNC-1];

  logic fwd, rev, a_edge;
  always_comb begin
    fwd = (prev == 2'b00 && cur == 2'b01) || (prev == 2'b01 && cur == 2'b11) ||
          (prev == 2'b11 && cur == 2'b10) || (prev == 2'b10 && cur == 2'b00);
    rev = (prev == 2'b01 && cur == 2'b00) || (prev == 2'b11 && cur == 2'b01) ||
          (prev == 2'b10 && cur == 2'b11) || (prev == 2'b00 && cur == 2'b10);
    a_edge = prev[1] ^ cur[1];
    case (res)
      RES_X4: begin up = fwd; dn = rev; end
      RES_X2: begin up = fwd & a_edge; dn = rev & a_edge; end
      RES_X1: begin
        up = (prev == 2'b01) && (cur == 2'b11);
        dn = (prev == 2'b11) && (cur == 2'b01);
      end
      default: begin up = 1'b0; dn = 1'b0; end
    endcase
  end
endmodule

// File: rtl/qenc_channel.sv
module qenc_channel
  import qenc_pkg::*;
#(
  parameter int CW = 25,
  localparam int LW = CW - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a,
  input  logic          b,
  input  logic          idx,
  input  logic          clr_all,
  input  logic          clr_tog,
  input  logic          reg_we,
  input  logic [3:0]    reg_sel,
  input  logic [7:0]    reg_wdata,
  output logic [CW-1:0] cnt,
  output logic [7:0]    mode_byte,
  output logic          flag_act,
  output logic          flag_pin,
  output logic          step
);
  res_e           res_q;
  flag_fn_e       fn_q;
  logic [LW-1:0]  preset_q;
  logic [CW-1:0]  cnt_q, cnt_n;
  logic           carry_n, borrow_n, cmp_n;
  logic           car_t, bor_t, cmp_t;
  logic           up, dn, idx_s;
  logic [31:0]    pre_tmp;

  qenc_decode #(.SYNC(2)) u_dec (
    .clk(clk), .rst(rst), .a(a), .b(b), .idx(idx), .res(res_q),
    .up(up), .dn(dn), .idx_s(idx_s)
  );

  // counter next state; a control write takes priority over a step
  always_comb begin
    cnt_n = cnt_q;
    car_t = 1'b0;
    bor_t = 1'b0;
    cmp_t = 1'b0;
    if (reg_we && reg_sel == OFS_CTRL && (reg_wdata[0] || reg_wdata[1])) begin
      cnt_n = reg_wdata[0] ? {1'b0, preset_q} : '0;
    end else if (up) begin
      if (cnt_q == {CW{1'b1}}) begin
        cnt_n = '0;
        car_t = 1'b1;
      end else cnt_n = cnt_q + CW'(1);
      cmp_t = (cnt_n == {1'b0, preset_q});
    end else if (dn) begin
      if (cnt_q == '0) begin
        cnt_n = {CW{1'b1}};
        bor_t = 1'b1;
      end else cnt_n = cnt_q - CW'(1);
      cmp_t = (cnt_n == {1'b0, preset_q});
    end
  end

  always_comb begin
    pre_tmp = 32'(preset_q);
    pre_tmp[8*reg_sel[1:0] +: 8] = reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= RES_HOLD;
      fn_q <= FN_CARRY;
      preset_q <= '0;
    end else if (reg_we) begin
      if (reg_sel < 4'd3) preset_q <= pre_tmp[LW-1:0];
      if (reg_sel == OFS_MODE) begin
        res_q <= res_e'(reg_wdata[4:3]);
        fn_q <= flag_fn_e'(reg_wdata[1:0]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      cnt_q <= '0;
      carry_n <= 1'b1;
      borrow_n <= 1'b1;
      cmp_n <= 1'b1;
    end else begin
      cnt_q <= cnt_n;
      if (clr_tog) begin
        carry_n <= 1'b1;
        borrow_n <= 1'b1;
        cmp_n <= 1'b1;
      end else begin
        carry_n <= carry_n ^ car_t;
        borrow_n <= borrow_n ^ bor_t;
        cmp_n <= cmp_n ^ cmp_t;
      end
    end
  end

  always_comb begin
    case (fn_q)
      FN_CARRY:        flag_act = ~carry_n;
      FN_COMPARE:      flag_act = ~cmp_n;
      FN_CARRY_BORROW: flag_act = ~carry_n | ~borrow_n;
      default:         flag_act = idx_s;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) flag_pin <= 1'b1;
    else     flag_pin <= (fn_q == FN_INDEX) ? flag_act : ~flag_act;
  end

  assign cnt       = cnt_q;
  assign mode_byte = {3'b000, res_q, 1'b0, fn_q};
  assign step      = up | dn;
endmodule

// File: rtl/qenc_irq_counter.sv
module qenc_irq_counter
  import qenc_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 25
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [7:0]     bus_addr,
  input  logic           bus_we,
  input  logic [7:0]     bus_wdata,
  output logic [7:0]     bus_rdata,
  input  logic [NCH-1:0] enc_a,
  input  logic [NCH-1:0] enc_b,
  input  logic [NCH-1:0] enc_idx,
  output logic [NCH-1:0] flag_pin,
  output logic           irq
);
  logic [CW-1:0]     cnt_arr [NCH];
  logic [7:0]        mode_arr [NCH];
  logic [NCH*CW-1:0] cnt_flat;
  logic [NCH-1:0]    flag_act, step_v, status_q, w1c;
  logic              irq_en_q, clr_all, clr_tog;
  logic [7:0]        rd_n;

  assign clr_all = bus_we && bus_addr == ADDR_CHOP && bus_wdata == CHOP_RESET;
  assign clr_tog = bus_we && bus_addr == ADDR_CLEAR && bus_wdata == 8'h00;
  assign w1c     = (bus_we && bus_addr == ADDR_STATUS) ? bus_wdata[NCH-1:0] : '0;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit = bus_addr[7] && (bus_addr[6:4] == 3'(i));
    qenc_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst(rst), .a(enc_a[i]), .b(enc_b[i]), .idx(enc_idx[i]),
      .clr_all(clr_all), .clr_tog(clr_tog),
      .reg_we(bus_we && hit), .reg_sel(bus_addr[3:0]), .reg_wdata(bus_wdata),
      .cnt(cnt_arr[i]), .mode_byte(mode_arr[i]),
      .flag_act(flag_act[i]), .flag_pin(flag_pin[i]), .step(step_v[i])
    );
    assign cnt_flat[i*CW +: CW] = cnt_arr[i];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_en_q <= 1'b0;
    else if (bus_we && bus_addr == ADDR_CHOP) begin
      if (bus_wdata == CHOP_RESET) irq_en_q <= 1'b0;
      else if (bus_wdata == CHOP_ENABLE) irq_en_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_tog) status_q <= '0;
    else status_q <= (status_q | (flag_act & {NCH{irq_en_q}})) & ~w1c;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= irq_en_q & (|status_q);
  end

  always_comb begin
    logic [31:0] cx;
    rd_n = 8'h00;
    cx = '0;
    if (bus_addr == ADDR_STATUS) rd_n = 8'(status_q);
    else if (bus_addr == ADDR_CHOP) rd_n = {7'b0, irq_en_q};
    else if (bus_addr[7]) begin
      for (int i = 0; i < NCH; i++) begin
        if (bus_addr[6:4] == 3'(i)) begin
          cx = 32'(cnt_arr[i]);
          if (bus_addr[3:2] == 2'b00) rd_n = cx[8*bus_addr[1:0] +: 8];
          else if (bus_addr[3:0] == OFS_MODE) rd_n = mode_arr[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= 8'h00;
    else     bus_rdata <= rd_n;
  end
endmodule

// File: rtl/qenc_irq_checker.sv
module qenc_irq_checker #(
  parameter int NCH = 8,
  parameter int CW  = 25
) (
  input logic              clk,
  input logic              rst,
  input logic [7:0]        bus_addr,
  input logic              bus_we,
  input logic [7:0]        bus_wdata,
  input logic              irq,
  input logic              irq_en,
  input logic [NCH-1:0]    status,
  input logic [NCH-1:0]    flag_act,
  input logic [NCH-1:0]    step,
  input logic [NCH*CW-1:0] cnt_flat
);
  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq);

  assert_reset_cmd_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 8'h11 && bus_wdata == 8'h01) |=> (cnt_flat == '0 && !irq_en));

  assert_clear_cmd_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 8'h12 && bus_wdata == 8'h00) |=> (status == '0));

  assert_count_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!bus_we && step == '0) |=> $stable(cnt_flat));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_status_source_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(status[i]) |-> $past(flag_act[i]));
  end
endmodule

bind qenc_irq_counter qenc_irq_checker #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .irq(irq), .irq_en(irq_en_q), .status(status_q), .flag_act(flag_act),
  .step(step_v), .cnt_flat(cnt_flat)
);

// File: tb/tb_qenc_irq_counter.sv
`timescale 1ns/1ps
module tb_qenc_irq_counter;
  localparam int NCH = 8;
  localparam int CW  = 9;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00, bus_rdata;
  logic bus_we = 1'b0;
  logic [NCH-1:0] enc_a = '0, enc_b = '0, enc_idx = '0, flag_pin;
  logic irq;
  int checks = 0, fails = 0;
  int ph [NCH];

  always #10 clk = ~clk;

  qenc_irq_counter #(.NCH(NCH), .CW(CW)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .flag_pin(flag_pin), .irq(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  function automatic logic [1:0] ab_of(input int p);
    case (p)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  task automatic set_phase(input int ch, input int p);
    logic [1:0] v;
    @(negedge clk);
    ph[ch] = p;
    v = ab_of(p);
    enc_a[ch] = v[1];
    enc_b[ch] = v[0];
    repeat (4) @(posedge clk);
  endtask

  task automatic move(input int ch, input int n, input bit go_up);
    for (int i = 0; i < n; i++) set_phase(ch, (ph[ch] + (go_up ? 1 : 3)) % 4);
    repeat (4) @(posedge clk);
  endtask

  task automatic read_cnt(input int ch, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(8'h80 + 8'(16 * ch), lo);
    rd(8'h81 + 8'(16 * ch), hi);
    v = {hi, lo};
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk(32'(flag_pin), 32'hFF, "R4 reset flag pins inactive");
    chk(32'(irq), 0, "R8 reset irq low");
    rd(8'h10, v); chk(32'(v), 0, "R8 reset status");
    rd(8'h11, v); chk(32'(v), 0, "R9 reset irq function disabled");
    rd(8'h80, v); chk(32'(v), 0, "R11 reset count");
  endtask

  task automatic t_modes();
    logic [15:0] c;
    logic [7:0] v;
    wr(8'h84, 8'h08); move(0, 4, 1);
    read_cnt(0, c); chk(32'(c), 1, "R2 x1 four phases");
    rd(8'h84, v); chk(32'(v), 32'h08, "R11 mode readback");
    wr(8'h84, 8'h10); move(0, 4, 1);
    read_cnt(0, c); chk(32'(c), 3, "R2 x2 four phases");
    wr(8'h84, 8'h18); move(0, 4, 1);
    read_cnt(0, c); chk(32'(c), 7, "R2 x4 four phases");
    move(0, 4, 0);
    read_cnt(0, c); chk(32'(c), 3, "R3 x4 down");
    wr(8'h84, 8'h00); move(0, 4, 1);
    read_cnt(0, c); chk(32'(c), 3, "R2 hold mode");
  endtask

  task automatic t_illegal();
    logic [15:0] c;
    wr(8'h84, 8'h18);
    set_phase(0, (ph[0] + 2) % 4);
    repeat (4) @(posedge clk);
    read_cnt(0, c); chk(32'(c), 3, "R3 illegal jump ignored");
    move(0, 1, 1);
    read_cnt(0, c); chk(32'(c), 4, "R3 count resumes");
  endtask

  task automatic t_load();
    logic [15:0] c;
    wr(8'h80, 8'hFF); wr(8'h85, 8'h01);
    move(0, 1, 1);
    read_cnt(0, c); chk(32'(c), 32'h100, "R1 load then top bit via step");
    wr(8'h80, 8'h5A); wr(8'h81, 8'h77); wr(8'h85, 8'h01);
    repeat (2) @(posedge clk);
    read_cnt(0, c); chk(32'(c), 32'h05A, "R1 load sets lower bits only");
  endtask

  task automatic t_carry();
    logic [15:0] c;
    logic [7:0] v;
    wr(8'h11, 8'h04);
    wr(8'h80, 8'hFF); wr(8'h85, 8'h01);
    move(0, 256, 1);
    read_cnt(0, c); chk(32'(c), 32'h1FF, "R4 at top of range");
    chk(32'(flag_pin[0]), 1, "R4 no carry yet");
    move(0, 1, 1);
    read_cnt(0, c); chk(32'(c), 0, "R4 wrapped to zero");
    chk(32'(flag_pin[0]), 0, "R4 carry flag active low");
    rd(8'h10, v); chk(32'(v), 1, "R8 status bit 0 set");
    chk(32'(irq), 1, "R8 irq raised");
    wr(8'h10, 8'h01); repeat (2) @(posedge clk);
    rd(8'h10, v); chk(32'(v), 1, "R8 status recaptured while flag active");
    wr(8'h12, 8'h00); repeat (3) @(posedge clk);
    rd(8'h10, v); chk(32'(v), 0, "R10 status cleared");
    chk(32'(flag_pin[0]), 1, "R10 toggle reset");
    chk(32'(irq), 0, "R10 irq dropped");
  endtask

  task automatic t_borrow();
    logic [15:0] c;
    logic [7:0] v;
    wr(8'h84, 8'h1A);
    move(0, 1, 0);
    read_cnt(0, c); chk(32'(c), 32'h1FF, "R5 underflow wrap");
    chk(32'(flag_pin[0]), 0, "R5 borrow raises carry-borrow flag");
    rd(8'h10, v); chk(32'(v), 1, "R5 borrow sets status");
    wr(8'h84, 8'h18); repeat (2) @(posedge clk);
    chk(32'(flag_pin[0]), 1, "R5 borrow ignored in carry function");
    wr(8'h10, 8'h01); repeat (2) @(posedge clk);
    rd(8'h10, v); chk(32'(v), 0, "R5 status stays clear without carry");
    wr(8'h12, 8'h00);
  endtask

  task automatic t_compare();
    logic [7:0] v;
    wr(8'h84, 8'h19);
    wr(8'h80, 8'h05); wr(8'h85, 8'h02);
    repeat (2) @(posedge clk);
    chk(32'(flag_pin[0]), 1, "R6 clear does not toggle compare");
    move(0, 5, 1);
    chk(32'(flag_pin[0]), 0, "R6 compare toggles on match");
    move(0, 1, 1);
    chk(32'(flag_pin[0]), 0, "R6 compare holds off match");
    move(0, 1, 0);
    chk(32'(flag_pin[0]), 1, "R6 compare toggles back on second match");
    wr(8'h12, 8'h00); repeat (2) @(posedge clk);
    rd(8'h10, v); chk(32'(v), 0, "R10 clear after compare");
  endtask

  task automatic t_index();
    logic [7:0] v;
    wr(8'hB4, 8'h1B); repeat (3) @(posedge clk);
    chk(32'(flag_pin[3]), 0, "R7 index low");
    @(negedge clk); enc_idx[3] = 1'b1; repeat (5) @(posedge clk);
    chk(32'(flag_pin[3]), 1, "R7 index flag active high");
    rd(8'h10, v); chk(32'(v), 32'h08, "R8 status names channel 3");
    @(negedge clk); enc_idx[3] = 1'b0; repeat (5) @(posedge clk);
    chk(32'(flag_pin[3]), 0, "R7 index follows input");
    wr(8'h10, 8'h08); repeat (2) @(posedge clk);
    rd(8'h10, v); chk(32'(v), 0, "R8 write one clears bit");
  endtask

  task automatic t_chop();
    logic [15:0] c;
    logic [7:0] v;
    wr(8'h11, 8'h02);
    rd(8'h11, v); chk(32'(v), 1, "R9 other value ignored");
    read_cnt(0, c); chk(32'(c), 5, "R9 count before reset");
    wr(8'h11, 8'h01); repeat (2) @(posedge clk);
    read_cnt(0, c); chk(32'(c), 0, "R9 counters reset");
    rd(8'h11, v); chk(32'(v), 0, "R9 function disabled");
    @(negedge clk); enc_idx[3] = 1'b1; repeat (6) @(posedge clk);
    chk(32'(flag_pin[3]), 1, "R7 pin active while disabled");
    rd(8'h10, v); chk(32'(v), 0, "R8 no capture while disabled");
    chk(32'(irq), 0, "R8 irq low while disabled");
    wr(8'h11, 8'h04); repeat (4) @(posedge clk);
    rd(8'h10, v); chk(32'(v), 32'h08, "R9 enable captures flag");
    chk(32'(irq), 1, "R9 irq after enable");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) ph[i] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    repeat (2) @(posedge clk);
    t_reset();
    t_modes();
    t_illegal();
    t_load();
    t_carry();
    t_borrow();
    t_compare();
    t_index();
    t_chop();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule